// File: doc/BRIEF.md
# CAN Fault Confinement Counters

This block keeps the two error counters of a CAN node and decides, from them, whether the node is error active, error passive or bus off. The protocol engine reports what happens on the bus through single-cycle strobes:
- a transmit error
- a receive error
- a frame sent cleanly
- a frame received cleanly
- while the node is bus off, each run of eleven recessive bits

The block updates the counters and the confinement state one clock after each strobe.

The result is packed into one 32-bit status word. It carries both counters, the state code and two early-warning flags. The warning flags rise once a counter reaches 96, which points to a heavily disturbed bus before the node goes passive. A separate one-cycle pulse marks entry into bus off, so that an interrupt source can capture it.

Recovery from bus off reuses the receive counter. While bus off, it counts the eleven-bit recessive groups. After 128 of them, both counters clear and the node is error active again. An active-low asynchronous reset returns everything to zero, which is the error-active state.

Top module: `can_fault_conf`

## Requirements
- R1: While reset is asserted, and after it, the status word reads all zero and the bus-off pulse is low.
- R2: Status word layout: bits [7:0] hold the transmit count, [15:8] the receive count, [17:16] the state code, bit 18 the transmit warning, bit 19 the receive warning, and [31:20] read zero.
- R3: Outside bus off, a transmit-error strobe adds 8 to the transmit count. A transmit-success strobe without a transmit error subtracts 1, and the count never goes below 0.
- R4: Outside bus off, a receive-error strobe adds 1 to the receive count, holding at 255. A receive-success strobe without a receive error subtracts 1, and the count never goes below 0.
- R5: Bit 18 is 1 exactly when the transmit count is at least 96. Bit 19 is 1 exactly when the receive count is at least 96.
- R6: The state code is 00 (error active) when both counts are below 128. It is 01 (error passive) when either count is 128 or more. The code 11 never appears.
- R7: A transmit error that would carry the transmit count past 255 puts the node in bus off. The node then shows state code 10, a transmit count of 255 and a receive count of 0. The bus-off pulse is high for exactly that one cycle.
- R8: While bus off, the error and success strobes leave both counters unchanged. Outside bus off, the recessive-group strobe has no effect.
- R9: While bus off, each recessive-group strobe adds 1 to the receive count. The 128th group clears both counts and sets the state code to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_err_i | input | 1 | Transmit error strobe |
| rx_err_i | input | 1 | Receive error strobe |
| tx_ok_i | input | 1 | Successful transmit strobe |
| rx_ok_i | input | 1 | Successful receive strobe |
| idle_grp_i | input | 1 | Eleven consecutive recessive bits seen |
| status_o | output | 32 | Packed counters, state code and warning flags |
| busoff_pulse_o | output | 1 | One-cycle pulse on entry to bus off |

## Verification
The assertions check, on every cycle, the properties that relate one cycle to the next. These are the zero upper bits, the absence of code 11, the eight-step transmit increment, the frozen counters in bus off, the pulse coinciding with a fresh bus-off entry, and the clearing on the final recovery group. Only the bench's scenarios show the rest: the exact thresholds at 96 and 128, both floors and the receive saturation, the entry exactly at a transmit count of 248, and the full 128-group recovery count. Those need long, ordered strobe sequences compared against an independent model.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'b00,
        FC_PASSIVE = 2'b01,
        FC_BUSOFF  = 2'b10
    } fc_state_e;
endpackage

// File: rtl/can_fc_tec_step.sv
// Next transmit error count outside bus off, and whether a transmit error
// would overflow the counter (the bus-off trigger).
module can_fc_tec_step #(
    parameter int CNT_W       = 8,
    parameter int TX_ERR_STEP = 8
) (
    input  logic [CNT_W-1:0] tec_i,
    input  logic             err_i,
    input  logic             ok_i,
    output logic [CNT_W-1:0] tec_o,
    output logic             ovf_o
);
    localparam logic [CNT_W:0] STEP_C = (CNT_W+1)'(TX_ERR_STEP);
    localparam logic [CNT_W:0] MAX_C  = {1'b0, {CNT_W{1'b1}}};

    logic [CNT_W:0] sum;

    always_comb begin
        sum   = {1'b0, tec_i} + STEP_C;
        ovf_o = err_i && (sum > MAX_C);
        if (err_i) begin
            tec_o = sum[CNT_W-1:0];
        end else if (ok_i && (tec_i != '0)) begin
            tec_o = tec_i - 1'b1;
        end else begin
            tec_o = tec_i;
        end
    end
endmodule

// File: rtl/can_fc_rec_step.sv
// Saturating up / floored down step of the receive error count.
module can_fc_rec_step #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] rec_i,
    input  logic             inc_i,
    input  logic             dec_i,
    output logic [CNT_W-1:0] rec_o
);
    always_comb begin
        if (inc_i) begin
            rec_o = (rec_i == {CNT_W{1'b1}}) ? rec_i : rec_i + 1'b1;
        end else if (dec_i && (rec_i != '0)) begin
            rec_o = rec_i - 1'b1;
        end else begin
            rec_o = rec_i;
        end
    end
endmodule

// File: rtl/can_fc_status_pack.sv
// Packs counters, state code and warning flags into the status word.
module can_fc_status_pack #(
    parameter int CNT_W    = 8,
    parameter int WARN_LIM = 96,
    parameter int STAT_W   = 32
) (
    input  logic [CNT_W-1:0]  tec_i,
    input  logic [CNT_W-1:0]  rec_i,
    input  logic [1:0]        state_i,
    output logic [STAT_W-1:0] word_o
);
    localparam int              USED_W = 2 * CNT_W + 4;
    localparam logic [CNT_W-1:0] WARN_C = CNT_W'(WARN_LIM);

    logic [CNT_W-1:0] cnt [2];
    logic [1:0]       warn;

    assign cnt[0] = tec_i;
    assign cnt[1] = rec_i;

    for (genvar g = 0; g < 2; g++) begin : g_warn
        assign warn[g] = (cnt[g] >= WARN_C);
    end

    assign word_o = {{(STAT_W-USED_W){1'b0}}, warn[1], warn[0], state_i, rec_i, tec_i};
endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf #(
    parameter int CNT_W        = 8,
    parameter int TX_ERR_STEP  = 8,
    parameter int PASSIVE_LIM  = 128,
    parameter int WARN_LIM     = 96,
    parameter int RECOV_GROUPS = 128,
    parameter int STAT_W       = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tx_err_i,
    input  logic              rx_err_i,
    input  logic              tx_ok_i,
    input  logic              rx_ok_i,
    input  logic              idle_grp_i,
    output logic [STAT_W-1:0] status_o,
    output logic              busoff_pulse_o
);
    import can_fc_pkg::*;

    localparam logic [CNT_W-1:0] PASS_C     = CNT_W'(PASSIVE_LIM);
    localparam logic [CNT_W-1:0] RECOV_LAST = CNT_W'(RECOV_GROUPS - 1);
    localparam logic [CNT_W-1:0] CNT_MAX    = {CNT_W{1'b1}};

    typedef struct packed {
        fc_state_e        st;
        logic [CNT_W-1:0] tec;
        logic [CNT_W-1:0] rec;
        logic             pulse;
    } fc_regs_t;

    fc_regs_t r_d, r_q;

    logic             in_bo;
    logic [CNT_W-1:0] tec_step;
    logic             tec_ovf;
    logic [CNT_W-1:0] rec_step;
    logic             rec_inc;
    logic             rec_dec;

    assign in_bo   = (r_q.st == FC_BUSOFF);
    assign rec_inc = in_bo ? idle_grp_i : rx_err_i;
    assign rec_dec = in_bo ? 1'b0 : rx_ok_i;

    can_fc_tec_step #(.CNT_W(CNT_W), .TX_ERR_STEP(TX_ERR_STEP)) u_tec (
        .tec_i (r_q.tec),
        .err_i (tx_err_i),
        .ok_i  (tx_ok_i),
        .tec_o (tec_step),
        .ovf_o (tec_ovf)
    );

    can_fc_rec_step #(.CNT_W(CNT_W)) u_rec (
        .rec_i (r_q.rec),
        .inc_i (rec_inc),
        .dec_i (rec_dec),
        .rec_o (rec_step)
    );

    always_comb begin
        r_d       = r_q;
        r_d.pulse = 1'b0;
        if (in_bo) begin
            if (idle_grp_i) begin
                if (r_q.rec == RECOV_LAST) begin
                    r_d.st  = FC_ACTIVE;
                    r_d.tec = '0;
                    r_d.rec = '0;
                end else begin
                    r_d.rec = rec_step;
                end
            end
        end else if (tec_ovf) begin
            r_d.st    = FC_BUSOFF;
            r_d.tec   = CNT_MAX;
            r_d.rec   = '0;
            r_d.pulse = 1'b1;
        end else begin
            r_d.tec = tec_step;
            r_d.rec = rec_step;
            r_d.st  = ((tec_step >= PASS_C) || (rec_step >= PASS_C)) ? FC_PASSIVE : FC_ACTIVE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    can_fc_status_pack #(.CNT_W(CNT_W), .WARN_LIM(WARN_LIM), .STAT_W(STAT_W)) u_pack (
        .tec_i   (r_q.tec),
        .rec_i   (r_q.rec),
        .state_i (r_q.st),
        .word_o  (status_o)
    );

    assign busoff_pulse_o = r_q.pulse;
endmodule

// File: rtl/can_fault_conf_chk.sv
module can_fault_conf_chk #(
    parameter int CNT_W        = 8,
    parameter int TX_ERR_STEP  = 8,
    parameter int RECOV_GROUPS = 128,
    parameter int STAT_W       = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              tx_err_i,
    input logic              rx_err_i,
    input logic              tx_ok_i,
    input logic              rx_ok_i,
    input logic              idle_grp_i,
    input logic [STAT_W-1:0] status_o,
    input logic              busoff_pulse_o
);
    localparam int              HI_LO  = 2 * CNT_W + 4;
    localparam logic [CNT_W:0]  STEP_C = (CNT_W+1)'(TX_ERR_STEP);
    localparam logic [CNT_W:0]  MAX_C  = {1'b0, {CNT_W{1'b1}}};
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(RECOV_GROUPS - 1);

    logic [CNT_W-1:0] tec, rec;
    logic [1:0]       st;
    logic [1:0]       warn;

    assign tec  = status_o[CNT_W-1:0];
    assign rec  = status_o[2*CNT_W-1:CNT_W];
    assign st   = status_o[2*CNT_W+1:2*CNT_W];
    assign warn = status_o[2*CNT_W+3:2*CNT_W+2];

    assert_hi_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        status_o[STAT_W-1:HI_LO] == '0);

    assert_no_code11_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st != 2'b11);

    assert_passive_warn_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st == 2'b01) |-> (warn != 2'b00));

    assert_tx_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st != 2'b10 && tx_err_i && ({1'b0, tec} + STEP_C <= MAX_C))
        |=> (tec == $past(tec) + STEP_C[CNT_W-1:0]));

    assert_pulse_entry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busoff_pulse_o |-> (st == 2'b10 && tec == MAX_C[CNT_W-1:0] && rec == '0));

    assert_busoff_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st == 2'b10 && !idle_grp_i)
        |=> (st == 2'b10 && tec == $past(tec) && rec == $past(rec) && !busoff_pulse_o));

    assert_recover_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st == 2'b10 && idle_grp_i && rec == LAST_C)
        |=> (st == 2'b00 && tec == '0 && rec == '0));

    logic unused_ok;
    assign unused_ok = ^{rx_err_i, tx_ok_i, rx_ok_i};
endmodule

bind can_fault_conf can_fault_conf_chk #(
    .CNT_W(CNT_W), .TX_ERR_STEP(TX_ERR_STEP), .RECOV_GROUPS(RECOV_GROUPS), .STAT_W(STAT_W)
) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .tx_err_i       (tx_err_i),
    .rx_err_i       (rx_err_i),
    .tx_ok_i        (tx_ok_i),
    .rx_ok_i        (rx_ok_i),
    .idle_grp_i     (idle_grp_i),
    .status_o       (status_o),
    .busoff_pulse_o (busoff_pulse_o)
);

// File: tb/can_fault_conf_tb_top.sv
module can_fault_conf_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_err = 1'b0, rx_err = 1'b0, tx_ok = 1'b0, rx_ok = 1'b0, grp = 1'b0;
    logic [31:0] status;
    logic        pulse;

    always #4 clk = ~clk;

    can_fault_conf dut_i (
        .clk_i (clk), .rst_ni (rst_n),
        .tx_err_i (tx_err), .rx_err_i (rx_err), .tx_ok_i (tx_ok), .rx_ok_i (rx_ok),
        .idle_grp_i (grp), .status_o (status), .busoff_pulse_o (pulse)
    );

    typedef struct {
        logic [31:0] st;
        logic        pl;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;

    // reference model, written from the requirements
    int m_tec = 0, m_rec = 0, m_st = 0;
    bit m_pl = 0;

    function automatic logic [31:0] exp_word();
        logic [31:0] w;
        w = '0;
        w[7:0]   = m_tec[7:0];
        w[15:8]  = m_rec[7:0];
        w[17:16] = m_st[1:0];
        w[18]    = (m_tec >= 96);
        w[19]    = (m_rec >= 96);
        return w;
    endfunction

    task automatic step(input bit te, re, to, ro, gr, input string tag);
        @(negedge clk);
        tx_err = te; rx_err = re; tx_ok = to; rx_ok = ro; grp = gr;
        m_pl = 0;
        if (m_st == 2) begin
            if (gr) begin
                if (m_rec == 127) begin m_tec = 0; m_rec = 0; m_st = 0; end
                else m_rec = m_rec + 1;
            end
        end else if (te && m_tec + 8 > 255) begin
            m_tec = 255; m_rec = 0; m_st = 2; m_pl = 1;
        end else begin
            if (te) m_tec = m_tec + 8;
            else if (to && m_tec > 0) m_tec = m_tec - 1;
            if (re) begin if (m_rec < 255) m_rec = m_rec + 1; end
            else if (ro && m_rec > 0) m_rec = m_rec - 1;
            m_st = (m_tec >= 128 || m_rec >= 128) ? 1 : 0;
        end
        q.push_back('{exp_word(), m_pl, tag});
    endtask

    task automatic direct_check(input string tag);
        n_chk++;
        if (status !== 32'h0 || pulse !== 1'b0) begin
            n_fail++;
            $display("FAIL %s: status=%h pulse=%b expected status=%h pulse=0", tag, status, pulse, 32'h0);
        end
    endtask

    // monitor: compares each result one cycle after its stimulus
    always @(posedge clk) begin
        #2;
        if (q.size() != 0) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (status !== e.st || pulse !== e.pl) begin
                n_fail++;
                $display("FAIL %s: status=%h pulse=%b expected status=%h pulse=%b",
                         e.tag, status, pulse, e.st, e.pl);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #20;
        direct_check("R1 in reset");
        @(negedge clk); rst_n = 1'b1;
        #2 direct_check("R1 after reset");

        // R3: steps of 8, decrement, floor at zero
        repeat (3) step(1, 0, 0, 0, 0, "R3 tx error +8");
        step(0, 0, 1, 0, 0, "R3 tx ok -1");
        step(1, 0, 1, 0, 0, "R3 tx error wins over ok");
        repeat (34) step(0, 0, 1, 0, 0, "R3 tx ok floor");

        // R4: increments, decrement floor
        repeat (5) step(0, 1, 0, 0, 0, "R4 rx error +1");
        repeat (7) step(0, 0, 0, 1, 0, "R4 rx ok floor");

        // R5: warning thresholds
        repeat (11) step(1, 0, 0, 0, 0, "R5 tx below 96");
        step(1, 0, 0, 0, 0, "R5 tx reaches 96");
        repeat (96) step(0, 1, 0, 0, 0, "R5 rx to 96");
        step(0, 0, 0, 1, 0, "R5 rx back to 95");
        step(1, 1, 0, 0, 0, "R2 both fields move");

        // R6: passive and back
        repeat (3) step(1, 0, 0, 0, 0, "R6 tx to 128 passive");
        step(0, 0, 1, 0, 0, "R6 tx 127 active");
        repeat (32) step(0, 1, 0, 0, 0, "R6 rx to 128 passive");
        step(0, 0, 0, 1, 0, "R6 rx 127 active");
        step(0, 0, 0, 0, 1, "R8 group ignored outside bus off");

        // R4 saturation
        repeat (130) step(0, 1, 0, 0, 0, "R4 rx saturates at 255");
        step(0, 0, 0, 0, 0, "R4 rx held");

        // mid-run reset
        @(negedge clk); rst_n = 1'b0; tx_err = 0; rx_err = 0; tx_ok = 0; rx_ok = 0; grp = 0;
        #1 direct_check("R1 reset mid run");
        m_tec = 0; m_rec = 0; m_st = 0; m_pl = 0;
        @(negedge clk); rst_n = 1'b1;

        // R7: bus off entry at 248 + 8
        repeat (10) step(0, 1, 0, 0, 0, "R7 rx preload");
        repeat (31) step(1, 0, 0, 0, 0, "R7 tx to 248");
        step(1, 1, 0, 0, 0, "R7 bus off entry");
        step(0, 0, 0, 0, 0, "R7 pulse drops");

        // R8: strobes ignored in bus off
        step(1, 1, 1, 1, 0, "R8 all strobes ignored");
        step(1, 0, 0, 0, 0, "R8 tx error ignored");
        step(0, 0, 1, 1, 0, "R8 ok strobes ignored");

        // R9: recovery
        step(1, 1, 1, 1, 1, "R9 group counts, others ignored");
        repeat (126) step(0, 0, 0, 0, 1, "R9 group count");
        step(0, 0, 0, 0, 0, "R9 still bus off at 127");
        step(0, 0, 0, 0, 1, "R9 128th group recovers");
        step(1, 0, 0, 0, 0, "R9 counting resumes");

        @(negedge clk); tx_err = 0; rx_err = 0; tx_ok = 0; rx_ok = 0; grp = 0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule